// File: doc/BRIEF.md
# Processor Tick Timer

This block is the tick timer of a processor core. It holds a 32-bit up-counter and a control word, both of which software reaches through a small special-register port. The port has a write strobe, a read strobe, a one-bit register select and a 32-bit data bus. The counter advances by one on every core clock while the timer is running. A comparator watches the low 28 bits of the counter against a programmed period. When they are equal, the block records a pending event. What happens to the counter next depends on the selected operating mode: it returns to zero, it stops, or it carries on.

The interrupt line is a level. It stays high while the pending flag and the enable flag are both set, and it stays high until software clears the pending flag. Software can only clear that flag, never set it.

Counting starts or stops only when a control write actually changes the mode field. Software can also load the counter directly at any time, whether or not the timer is running. Address decoding and privilege checks belong to the surrounding logic.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the control word, the counter, the running state, `irq_o`, `sr_rvalid` and `sr_rdata` are all zero.
- R2: The control word (select 0) has this layout: bits 31:30 are the mode (00 off, 01 restart, 10 single-shot, 11 continuous), bit 29 is interrupt enable, bit 28 is pending and bits 27:0 are the period. A read of the control word returns the stored mode, enable and period, together with the current pending flag.
- R3: A control write whose mode differs from the stored mode starts counting when the new mode is non-zero, or stops counting when the new mode is 00, at that clock edge. A control write with an unchanged mode leaves the running state as it was. While the timer is stopped, the counter holds its value.
- R4: While the timer is running, a match occurs in any cycle where counter bits 27:0 equal the period. A match sets pending on that edge, whether or not interrupts are enabled.
- R5: In restart mode (01) a match returns the counter to 0 on that edge.
- R6: In single-shot mode (10) a match stops counting, and the counter keeps the matching value.
- R7: In continuous mode (11) the counter increments through a match and wraps from 0xFFFFFFFF to 0.
- R8: A control write with bit 28 = 1 keeps the current pending value. A control write with bit 28 = 0 clears pending, unless a match sets it on the same edge.
- R9: A write with select 1 loads the counter with the write data on that edge. The load overrides any increment and suppresses the match in that cycle.
- R10: A read strobe produces `sr_rvalid` and `sr_rdata` on the next edge. For select 1 the data is the counter value held in the cycle the strobe was presented.
- R11: `irq_o` equals pending AND enable, updating on the same edge as those flags. It stays high until a control write clears pending or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_we | input | 1 | Register write strobe |
| sr_re | input | 1 | Register read strobe |
| sr_sel | input | 1 | Register select: 0 control word, 1 counter |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Registered read data |
| sr_rvalid | output | 1 | Read data valid, one cycle after `sr_re` |
| irq_o | output | 1 | Level timer interrupt |

## Verification
Every write takes effect on the clock edge that samples it. Counting therefore begins with the increment on the following edge, and a match is seen one edge after the counter holds the period value. Pending and the interrupt rise on that match edge, and read data appears one edge after the read strobe, carrying the counter value from the strobe cycle. The bench drives inputs and samples outputs on falling edges. It counts every task call as exactly one cycle, so that each expected counter value and each interrupt check falls in the exact cycle these latencies give. Expected read data is queued at the moment the strobe is issued, and the monitor pops the queue in the cycle `sr_rvalid` shows it.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tmode_e;

  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_COUNT = 1'b1;

endpackage

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tick_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wdata,
  input  logic                 match_i,
  output tmode_e               mode_o,
  output logic                 ie_o,
  output logic                 pend_o,
  output logic [DW-5:0]        period_o,
  output logic                 ie_nxt_o,
  output logic                 pend_nxt_o,
  output logic                 mode_chg_o,
  output logic                 run_req_o
);
  localparam int PW       = DW - 4;
  localparam int IE_POS   = DW - 3;
  localparam int PEND_POS = DW - 4;

  tmode_e          mode_q;
  logic            ie_q;
  logic            pend_q;
  logic [PW-1:0]   period_q;
  tmode_e          new_mode;

  always_comb begin
    new_mode   = tmode_e'(wdata[DW-1:DW-2]);
    mode_chg_o = wr_en && (new_mode != mode_q);
    run_req_o  = (new_mode != TM_OFF);
    ie_nxt_o   = wr_en ? wdata[IE_POS] : ie_q;
    pend_nxt_o = ((wr_en && !wdata[PEND_POS]) ? 1'b0 : pend_q) | match_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= TM_OFF;
      ie_q     <= 1'b0;
      pend_q   <= 1'b0;
      period_q <= '0;
    end else begin
      if (wr_en) begin
        mode_q   <= new_mode;
        period_q <= wdata[PW-1:0];
      end
      ie_q   <= ie_nxt_o;
      pend_q <= pend_nxt_o;
    end
  end

  assign mode_o   = mode_q;
  assign ie_o     = ie_q;
  assign pend_o   = pend_q;
  assign period_o = period_q;

  // R4: a match always records pending
  p_match_sets_pend_r4: assert property (@(posedge clk) disable iff (rst)
    match_i |=> pend_q);

  // R8: writing the pending bit as 1 keeps it
  p_pend_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[PEND_POS] && pend_q) |=> pend_q);

  // R8: writing the pending bit as 0 clears it
  p_pend_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wdata[PEND_POS] && !match_i) |=> !pend_q);

  // R8: software can never set pending
  p_pend_no_sw_set_r8: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !match_i) |=> !pend_q);

endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 28
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_we,
  input  logic [DW-1:0]   wdata,
  input  tmode_e          mode_i,
  input  logic [PW-1:0]   period_i,
  input  logic            mode_chg_i,
  input  logic            run_req_i,
  output logic [DW-1:0]   cnt_o,
  output logic            run_o,
  output logic            match_o
);
  logic [DW-1:0] cnt_q;
  logic          run_q;
  logic          hit;

  always_comb begin
    hit     = (cnt_q[PW-1:0] == period_i);
    match_o = run_q && !cnt_we && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (mode_chg_i) begin
      run_q <= run_req_i;
    end else if (match_o && mode_i == TM_ONESHOT) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata;
    end else if (match_o && mode_i == TM_RESTART) begin
      cnt_q <= '0;
    end else if (match_o && mode_i == TM_ONESHOT) begin
      cnt_q <= cnt_q;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R3: stopped counter holds
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_we) |=> $stable(cnt_q));

  // R3: mode change to a running mode starts counting
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_chg_i && run_req_i) |=> run_q);

  // R3: mode change to off stops counting
  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_chg_i && !run_req_i) |=> !run_q);

  // R3: unchanged mode leaves running state alone
  p_same_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_chg_i && !match_o) |=> $stable(run_q));

  // R5: restart match returns count to zero
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (match_o && mode_i == TM_RESTART) |=> (cnt_q == '0));

  // R6: single-shot match stops and holds
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (match_o && mode_i == TM_ONESHOT && !mode_chg_i) |=> (!run_q && $stable(cnt_q)));

  // R7: running count steps by one, wrapping at the top
  p_free_step_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cnt_we && !(match_o && mode_i != TM_FREE)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R9: a counter write loads the data
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/tt_readback.sv
module tt_readback #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            re,
  input  logic            sel,
  input  logic [DW-1:0]   ctrl_word,
  input  logic [DW-1:0]   cnt,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) begin
        rdata <= sel ? cnt : ctrl_word;
      end
    end
  end

  // R10: valid follows the strobe by one cycle
  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);

  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rvalid);

  // R10: counter reads carry the strobe-cycle value
  p_count_read_r10: assert property (@(posedge clk) disable iff (rst)
    (re && sel) |=> (rdata == $past(cnt)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sr_we,
  input  logic          sr_re,
  input  logic          sr_sel,
  input  logic [DW-1:0] sr_wdata,
  output logic [DW-1:0] sr_rdata,
  output logic          sr_rvalid,
  output logic          irq_o
);
  localparam int PW = DW - 4;

  logic          ctrl_we;
  logic          cnt_we;
  tmode_e        mode;
  logic          ie;
  logic          pend;
  logic [PW-1:0] period;
  logic          ie_nxt;
  logic          pend_nxt;
  logic          mode_chg;
  logic          run_req;
  logic [DW-1:0] cnt;
  logic          run;
  logic          match;
  logic [DW-1:0] ctrl_word;
  logic          irq_q;

  assign ctrl_we   = sr_we && (sr_sel == SEL_CTRL);
  assign cnt_we    = sr_we && (sr_sel == SEL_COUNT);
  assign ctrl_word = {mode, ie, pend, period};

  tt_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctrl_we),
    .wdata      (sr_wdata),
    .match_i    (match),
    .mode_o     (mode),
    .ie_o       (ie),
    .pend_o     (pend),
    .period_o   (period),
    .ie_nxt_o   (ie_nxt),
    .pend_nxt_o (pend_nxt),
    .mode_chg_o (mode_chg),
    .run_req_o  (run_req)
  );

  tt_counter #(.DW(DW), .PW(PW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cnt_we     (cnt_we),
    .wdata      (sr_wdata),
    .mode_i     (mode),
    .period_i   (period),
    .mode_chg_i (mode_chg),
    .run_req_i  (run_req),
    .cnt_o      (cnt),
    .run_o      (run),
    .match_o    (match)
  );

  tt_readback #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .re        (sr_re),
    .sel       (sr_sel),
    .ctrl_word (ctrl_word),
    .cnt       (cnt),
    .rdata     (sr_rdata),
    .rvalid    (sr_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ie_nxt && pend_nxt;
  end

  assign irq_o = irq_q;

  // R11: the interrupt line tracks pending AND enable
  p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ie && pend));

  // R11: the interrupt holds until a control write
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ctrl_we) |=> irq_o);

  // R3: the counter is idle whenever the mode is off
  p_off_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_OFF) |-> !run);

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sr_we = 1'b0;
  logic        sr_re = 1'b0;
  logic        sr_sel = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        sr_rvalid;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  tick_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .sr_we     (sr_we),
    .sr_re     (sr_re),
    .sr_sel    (sr_sel),
    .sr_wdata  (sr_wdata),
    .sr_rdata  (sr_rdata),
    .sr_rvalid (sr_rvalid),
    .irq_o     (irq_o)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && sr_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected read data %08h, expected none", sr_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (sr_rdata !== e) begin
          fails++;
          $display("FAIL %s read got %08h expected %08h", t, sr_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    sr_we = 1'b1; sr_sel = sel; sr_wdata = d;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [31:0] e, input string t);
    sr_re = 1'b1; sr_sel = sel;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    sr_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s irq_o got %0b expected %0b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, got running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk_irq(1'b0, "R1 reset");
    checks++;
    if (sr_rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rvalid got %0b expected 0", sr_rvalid);
    end
    rd(1'b0, 32'h0, "R1 ctrl after reset");
    rd(1'b1, 32'h0, "R1 count after reset");

    // R9 / R3: load while off, counter holds
    wr(1'b1, 32'h1234_5678);
    rd(1'b1, 32'h1234_5678, "R9 load while off");
    rd(1'b1, 32'h1234_5678, "R3 off holds");
    chk_irq(1'b0, "R3 off no irq");

    // continuous, period 10, enabled
    wr(1'b1, 32'h0);
    wr(1'b0, 32'hE000_000A);            // N0
    rd(1'b1, 32'd0, "R3 start count");   // N1
    rd(1'b1, 32'd1, "R3 counting");      // N2
    idle(8);                             // N10
    chk_irq(1'b0, "R4 before match");
    idle(1);                             // N11
    chk_irq(1'b1, "R11 match raises irq");
    rd(1'b0, 32'hF000_000A, "R2 ctrl with pending"); // N12
    rd(1'b1, 32'd12, "R7 counts through match");    // N13
    wr(1'b0, 32'hF000_000A);                         // N14
    chk_irq(1'b1, "R8 keep pending");
    rd(1'b1, 32'd14, "R3 same mode no restart");    // N15
    wr(1'b0, 32'hE000_000A);                         // N16
    chk_irq(1'b0, "R8 clear pending");
    rd(1'b0, 32'hE000_000A, "R8 pending cleared");  // N17
    rd(1'b1, 32'd17, "R10 count read value");       // N18

    // restart, period 3, interrupts disabled
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h4000_0003);             // N0
    rd(1'b1, 32'd0, "R5 restart 0");
    rd(1'b1, 32'd1, "R5 restart 1");
    rd(1'b1, 32'd2, "R5 restart 2");
    rd(1'b1, 32'd3, "R5 restart 3");
    rd(1'b1, 32'd0, "R5 wrap to zero");  // N5
    chk_irq(1'b0, "R11 disabled no irq");
    rd(1'b0, 32'h5000_0003, "R4 pending without enable"); // N6
    wr(1'b0, 32'h7000_0003);             // N7
    chk_irq(1'b1, "R11 enable raises irq");
    rd(1'b1, 32'd3, "R3 enable write keeps running"); // N8
    rd(1'b1, 32'd0, "R5 second restart");             // N9

    // single-shot, period 8, preload 5
    wr(1'b0, 32'h0);
    chk_irq(1'b0, "R8 off write clears");
    wr(1'b1, 32'd5);
    wr(1'b0, 32'hA000_0008);             // N0
    chk_irq(1'b0, "R6 before match");
    rd(1'b1, 32'd5, "R6 step 5");
    rd(1'b1, 32'd6, "R6 step 6");
    rd(1'b1, 32'd7, "R6 step 7");        // N3
    chk_irq(1'b0, "R6 not yet");
    rd(1'b1, 32'd8, "R6 step 8");        // N4
    chk_irq(1'b1, "R6 match irq");
    idle(10);
    rd(1'b1, 32'd8, "R6 stopped holds");
    wr(1'b0, 32'hA000_0008);
    chk_irq(1'b0, "R8 clear in single-shot");
    idle(3);
    rd(1'b1, 32'd8, "R3 same mode stays stopped");

    // continuous wrap, period 1
    wr(1'b0, 32'h0);
    wr(1'b1, 32'hFFFF_FFFE);
    wr(1'b0, 32'hE000_0001);             // N0
    rd(1'b1, 32'hFFFF_FFFE, "R7 preload");
    rd(1'b1, 32'hFFFF_FFFF, "R7 top");
    rd(1'b1, 32'h0000_0000, "R7 wrap");  // N3
    chk_irq(1'b0, "R4 before low match");
    idle(1);                             // N4
    chk_irq(1'b1, "R4 match after wrap");
    wr(1'b0, 32'hE000_0001);
    chk_irq(1'b0, "R8 clear");

    // preload while running, low 28 bits compared
    wr(1'b1, 32'h5000_0000);             // N0
    chk_irq(1'b0, "R9 load overrides");
    idle(1);
    chk_irq(1'b0, "R4 no match yet");
    idle(1);                             // N2
    chk_irq(1'b1, "R4 low-bit match");
    rd(1'b1, 32'h5000_0002, "R9 counting from load"); // N3
    wr(1'b0, 32'h0);                     // N4
    chk_irq(1'b0, "R8 off clears irq");
    rd(1'b1, 32'h5000_0004, "R3 stop value");
    idle(5);
    rd(1'b1, 32'h5000_0004, "R3 stopped holds");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 reads outstanding got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule